// File: doc/BRIEF.md
# Platform Status and Control Register Block

This block is a 4 KB window of 32-bit platform registers on a simple request/response bus. Software reads it to learn how the board was built and configured: fixed identification words, a memory-ready status word, a clock divider description that carries the reference clock frequency, the set of enabled serial links, and the installed memory size. One register accepts commands: writing it with the reset bit set sends a one-cycle system reset request to the reset controller.

Each request is taken in one cycle and answered in the next. A small state machine holds the answer: ST_IDLE (ready, waiting), then one of ST_READ_ACK (read data returned), ST_WRITE_ACK (write absorbed), ST_RESET_ACK (write absorbed and reset request raised) or ST_ERROR_ACK (access refused, zero data, error flag raised), and always back to ST_IDLE. The transitions are: IDLE to READ_ACK on a 32-bit read of a readable register; IDLE to WRITE_ACK on a 32-bit write of a known register that does not trigger reset; IDLE to RESET_ACK on a 32-bit write of the soft-reset register with bit 4 set; IDLE to ERROR_ACK on any other accepted request; every ACK state to IDLE unconditionally. Only the low 16 address bits take part in decoding, and a request with a size other than 32 bits is refused whatever its address.

Top module: `plat_regs`

## Requirements
- R1: `req_ready` is high exactly in the idle state; a request with `req_valid` high while `req_ready` is high is accepted at that clock edge, `rsp_valid` is high for exactly the following cycle, and `req_ready` is low during that response cycle.
- R2: 32-bit reads of offsets 0x00, 0x04 and 0x08 return 0x00000000; a 32-bit read of offset 0x14 returns 0x00000005 (bit 0 locked, bit 2 calibrated).
- R3: A 32-bit read of offset 0x30 returns 0x01 in bits 31:24, 0x01 in bits 23:16, `refclk_mhz` in bits 15:8 and 0x01 in bits 7:0.
- R4: A 32-bit read of offset 0x34 returns 0 in bit 0, `link_en[i]` in bit 1+i for each link, and zero in all other bits.
- R5: A 32-bit read of offset 0x38 returns `mem_gbytes` in bits 3:0, all ones in bits 15:4 and zero in bits 31:16.
- R6: `req_size` encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit; any size other than 2 is refused: the response carries zero data, `access_err` is high in the response cycle, and a write changes nothing and raises no reset request.
- R7: A 32-bit write to offset 0x10 with data bit 4 set makes `sys_reset_req` high for exactly the response cycle; with bit 4 clear no reset request is raised and no error is flagged.
- R8: 32-bit writes to offsets 0x00, 0x04, 0x08, 0x14, 0x18, 0x30, 0x34 and 0x38 are acknowledged without error and change no value later read back.
- R9: Any other offset is unknown: a read returns zero and a write is discarded, both with `access_err` high in the response cycle; reads of 0x10 and 0x18, offsets not a multiple of 4, offsets above 0x38 and the spare range count as unknown.
- R10: While and after reset, before any request, `rsp_valid`, `sys_reset_req` and `access_err` are low and `req_ready` is high.
- R11: Address bits above bit 15 do not affect decoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (2 = 32-bit) |
| req_addr | input | ADDR_W (32) | Byte address; low 16 bits decoded |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 32 | Read data, zero for writes and refused accesses |
| access_err | output | 1 | Refused access flag, one cycle |
| sys_reset_req | output | 1 | System reset request pulse |
| refclk_mhz | input | 8 | Reference clock frequency in MHz |
| link_en | input | 3 | Per-link enable |
| mem_gbytes | input | 4 | Installed memory in whole gigabytes |

## Verification
The in-RTL assertions watch the timing skeleton on every cycle: a taken request always produces a response in the next cycle, responses and reset pulses last one cycle, ready is low while a response is out, a refused access never carries data or a reset pulse, and a wrong-size request always ends in an error response. The register contents themselves, which offsets are known for reads versus writes, the effect of the reset bit value, the independence of decoding from the upper address bits and the fact that writes to read-only words leave their values intact can only be shown by the bench's read and write scenarios compared against values worked out from the register layout.

// File: rtl/plat_regs_pkg.sv
package plat_regs_pkg;

    localparam int DATA_W = 32;
    localparam int DEC_W  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_ACK,
        ST_WRITE_ACK,
        ST_RESET_ACK,
        ST_ERROR_ACK
    } plat_state_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } acc_size_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_BUILD_ID,
        SEL_CORE_CL,
        SEL_WRAP_CL,
        SEL_SOFT_RST,
        SEL_MEM_STAT,
        SEL_LINK_STAT,
        SEL_CLK_DIV,
        SEL_BUILD_CFG,
        SEL_MEM_CFG
    } reg_sel_e;

    localparam logic [DEC_W-1:0] OFF_BUILD_ID  = 16'h0000;
    localparam logic [DEC_W-1:0] OFF_CORE_CL   = 16'h0004;
    localparam logic [DEC_W-1:0] OFF_WRAP_CL   = 16'h0008;
    localparam logic [DEC_W-1:0] OFF_SOFT_RST  = 16'h0010;
    localparam logic [DEC_W-1:0] OFF_MEM_STAT  = 16'h0014;
    localparam logic [DEC_W-1:0] OFF_LINK_STAT = 16'h0018;
    localparam logic [DEC_W-1:0] OFF_CLK_DIV   = 16'h0030;
    localparam logic [DEC_W-1:0] OFF_BUILD_CFG = 16'h0034;
    localparam logic [DEC_W-1:0] OFF_MEM_CFG   = 16'h0038;

    localparam int RST_BIT = 4;

endpackage

// File: rtl/plat_addr_decode.sv
module plat_addr_decode
    import plat_regs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam int USE_W = (ADDR_W < DEC_W) ? ADDR_W : DEC_W;

    logic [DEC_W-1:0] offset;

    always_comb begin
        offset = '0;
        offset[USE_W-1:0] = addr[USE_W-1:0];
    end

    always_comb begin
        case (offset)
            OFF_BUILD_ID:  sel = SEL_BUILD_ID;
            OFF_CORE_CL:   sel = SEL_CORE_CL;
            OFF_WRAP_CL:   sel = SEL_WRAP_CL;
            OFF_SOFT_RST:  sel = SEL_SOFT_RST;
            OFF_MEM_STAT:  sel = SEL_MEM_STAT;
            OFF_LINK_STAT: sel = SEL_LINK_STAT;
            OFF_CLK_DIV:   sel = SEL_CLK_DIV;
            OFF_BUILD_CFG: sel = SEL_BUILD_CFG;
            OFF_MEM_CFG:   sel = SEL_MEM_CFG;
            default:       sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/plat_read_mux.sv
module plat_read_mux
    import plat_regs_pkg::*;
#(
    parameter int LINKS = 3,
    parameter int MHZ_W = 8,
    parameter int GB_W  = 4
) (
    input  reg_sel_e          sel,
    input  logic [MHZ_W-1:0]  refclk_mhz,
    input  logic [LINKS-1:0]  link_en,
    input  logic [GB_W-1:0]   mem_gbytes,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_known
);

    localparam int FREQ_LSB = GB_W;
    localparam int FREQ_W   = 16 - GB_W;

    logic [DATA_W-1:0] clk_div_word;
    logic [DATA_W-1:0] build_cfg_word;
    logic [DATA_W-1:0] mem_cfg_word;
    logic [DATA_W-1:0] mem_stat_word;

    always_comb begin
        clk_div_word        = '0;
        clk_div_word[7:0]   = 8'd1;
        clk_div_word[8 +: MHZ_W] = refclk_mhz;
        clk_div_word[23:16] = 8'd1;
        clk_div_word[31:24] = 8'd1;
    end

    always_comb begin
        mem_stat_word    = '0;
        mem_stat_word[0] = 1'b1;
        mem_stat_word[2] = 1'b1;
    end

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_cfg_bit
            if (i >= 1 && i <= LINKS) begin : g_link
                assign build_cfg_word[i] = link_en[i-1];
            end else begin : g_zero
                assign build_cfg_word[i] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        mem_cfg_word = '0;
        mem_cfg_word[GB_W-1:0] = mem_gbytes;
        mem_cfg_word[FREQ_LSB +: FREQ_W] = '1;
    end

    always_comb begin
        rd_known = 1'b1;
        unique case (sel)
            SEL_BUILD_ID,
            SEL_CORE_CL,
            SEL_WRAP_CL:   rd_data = '0;
            SEL_MEM_STAT:  rd_data = mem_stat_word;
            SEL_CLK_DIV:   rd_data = clk_div_word;
            SEL_BUILD_CFG: rd_data = build_cfg_word;
            SEL_MEM_CFG:   rd_data = mem_cfg_word;
            default: begin
                rd_data  = '0;
                rd_known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/plat_ctl_fsm.sv
module plat_ctl_fsm
    import plat_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              wr_reset_bit,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_known,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              access_err,
    output logic              sys_reset_req
);

    plat_state_e       state_q, state_d;
    logic [DATA_W-1:0] rdata_q;
    logic              size_ok;
    logic              accept;

    assign size_ok = (req_size == SZ_32);
    assign accept  = req_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!size_ok) begin
                        state_d = ST_ERROR_ACK;
                    end else if (req_write) begin
                        if (sel == SEL_NONE) begin
                            state_d = ST_ERROR_ACK;
                        end else if (sel == SEL_SOFT_RST && wr_reset_bit) begin
                            state_d = ST_RESET_ACK;
                        end else begin
                            state_d = ST_WRITE_ACK;
                        end
                    end else if (rd_known) begin
                        state_d = ST_READ_ACK;
                    end else begin
                        state_d = ST_ERROR_ACK;
                    end
                end
            end
            ST_READ_ACK,
            ST_WRITE_ACK,
            ST_RESET_ACK,
            ST_ERROR_ACK: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept) begin
            rdata_q <= (state_d == ST_READ_ACK) ? rd_data : '0;
        end
    end

    always_comb begin
        req_ready     = 1'b0;
        rsp_valid     = 1'b0;
        access_err    = 1'b0;
        sys_reset_req = 1'b0;
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_READ_ACK,
            ST_WRITE_ACK: rsp_valid = 1'b1;
            ST_RESET_ACK: begin
                rsp_valid     = 1'b1;
                sys_reset_req = 1'b1;
            end
            ST_ERROR_ACK: begin
                rsp_valid  = 1'b1;
                access_err = 1'b1;
            end
            default: ;
        endcase
    end

    assign rsp_rdata = rsp_valid ? rdata_q : '0;

    // R1
    accept_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R1
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R1
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R7
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);

    // R7
    rst_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> (rsp_valid && !access_err));

    // R9
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |-> (rsp_rdata == '0));

    // R6
    size_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_size != SZ_32)) |=> (access_err && !sys_reset_req));

endmodule

// File: rtl/plat_regs.sv
module plat_regs
    import plat_regs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINKS  = 3,
    parameter int MHZ_W  = 8,
    parameter int GB_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              access_err,
    output logic              sys_reset_req,
    input  logic [MHZ_W-1:0]  refclk_mhz,
    input  logic [LINKS-1:0]  link_en,
    input  logic [GB_W-1:0]   mem_gbytes
);

    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_data;
    logic              rd_known;

    plat_addr_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr (req_addr),
        .sel  (sel)
    );

    plat_read_mux #(
        .LINKS (LINKS),
        .MHZ_W (MHZ_W),
        .GB_W  (GB_W)
    ) u_rmux (
        .sel        (sel),
        .refclk_mhz (refclk_mhz),
        .link_en    (link_en),
        .mem_gbytes (mem_gbytes),
        .rd_data    (rd_data),
        .rd_known   (rd_known)
    );

    plat_ctl_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_size      (req_size),
        .wr_reset_bit  (req_wdata[RST_BIT]),
        .sel           (sel),
        .rd_data       (rd_data),
        .rd_known      (rd_known),
        .req_ready     (req_ready),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .access_err    (access_err),
        .sys_reset_req (sys_reset_req)
    );

endmodule

// File: tb/plat_regs_tb.sv
module plat_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        access_err;
    logic        sys_reset_req;
    logic [7:0]  refclk_mhz = 8'd25;
    logic [2:0]  link_en = 3'b101;
    logic [3:0]  mem_gbytes = 4'd2;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    plat_regs u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_size      (req_size),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .access_err    (access_err),
        .sys_reset_req (sys_reset_req),
        .refclk_mhz    (refclk_mhz),
        .link_en       (link_en),
        .mem_gbytes    (mem_gbytes)
    );

    // write, size, addr, wdata, expected rdata, expected err, expected reset
    localparam int NV = 21;
    localparam logic [100:0] VEC [NV] = '{
        {1'b0, 2'd2, 32'h0000_0000, 32'h0, 32'h0000_0000, 1'b0, 1'b0},
        {1'b0, 2'd2, 32'h0000_0004, 32'h0, 32'h0000_0000, 1'b0, 1'b0},
        {1'b0, 2'd2, 32'h0000_0008, 32'h0, 32'h0000_0000, 1'b0, 1'b0},
        {1'b0, 2'd2, 32'h0000_0014, 32'h0, 32'h0000_0005, 1'b0, 1'b0},
        {1'b0, 2'd2, 32'h0000_0030, 32'h0, 32'h0101_1901, 1'b0, 1'b0},
        {1'b0, 2'd2, 32'h0000_0034, 32'h0, 32'h0000_000A, 1'b0, 1'b0},
        {1'b0, 2'd2, 32'h0000_0038, 32'h0, 32'h0000_FFF2, 1'b0, 1'b0},
        {1'b0, 2'd0, 32'h0000_0014, 32'h0, 32'h0000_0000, 1'b1, 1'b0},
        {1'b0, 2'd3, 32'h0000_0030, 32'h0, 32'h0000_0000, 1'b1, 1'b0},
        {1'b1, 2'd2, 32'h0000_0014, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0},
        {1'b0, 2'd2, 32'h0000_0014, 32'h0, 32'h0000_0005, 1'b0, 1'b0},
        {1'b1, 2'd2, 32'h0000_0010, 32'h0000_0010, 32'h0, 1'b0, 1'b1},
        {1'b1, 2'd2, 32'h0000_0010, 32'hFFFF_FFEF, 32'h0, 1'b0, 1'b0},
        {1'b1, 2'd1, 32'h0000_0010, 32'h0000_0010, 32'h0, 1'b1, 1'b0},
        {1'b0, 2'd2, 32'h0000_004C, 32'h0, 32'h0000_0000, 1'b1, 1'b0},
        {1'b0, 2'd2, 32'h0000_0010, 32'h0, 32'h0000_0000, 1'b1, 1'b0},
        {1'b0, 2'd2, 32'h0000_0016, 32'h0, 32'h0000_0000, 1'b1, 1'b0},
        {1'b0, 2'd2, 32'hABCD_0038, 32'h0, 32'h0000_FFF2, 1'b0, 1'b0},
        {1'b1, 2'd2, 32'h0000_0024, 32'h1234_5678, 32'h0, 1'b1, 1'b0},
        {1'b1, 2'd2, 32'h0000_0030, 32'h0000_0000, 32'h0, 1'b0, 1'b0},
        {1'b0, 2'd2, 32'h0000_0030, 32'h0, 32'h0101_1901, 1'b0, 1'b0}
    };

    function automatic string tag_of(int i);
        case (i)
            0, 1, 2, 3: return "R2";
            4:          return "R3";
            5:          return "R4";
            6:          return "R5";
            7, 8, 13:   return "R6";
            9, 10, 19, 20: return "R8";
            11, 12:     return "R7";
            14, 15, 16, 18: return "R9";
            17:         return "R11";
            default:    return "R1";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // Drives one request and checks the response cycle.
    task automatic access(string req, logic wr, logic [1:0] sz, logic [31:0] a,
                          logic [31:0] wd, logic [31:0] exp_d, logic exp_e, logic exp_r);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_size  = sz;
        req_addr  = a;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req, "rsp_valid", {31'b0, rsp_valid}, 32'd1);
        chk("R1", "req_ready in response", {31'b0, req_ready}, 32'd0);
        chk(req, "rsp_rdata", rsp_rdata, exp_d);
        chk(req, "access_err", {31'b0, access_err}, {31'b0, exp_e});
        chk(req, "sys_reset_req", {31'b0, sys_reset_req}, {31'b0, exp_r});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        chk("R10", "rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
        chk("R10", "sys_reset_req in reset", {31'b0, sys_reset_req}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10", "req_ready after reset", {31'b0, req_ready}, 32'd1);
        chk("R10", "access_err after reset", {31'b0, access_err}, 32'd0);
        chk("R10", "rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            access(tag_of(i), VEC[i][100], VEC[i][99:98], VEC[i][97:66],
                   VEC[i][65:34], VEC[i][33:2], VEC[i][1], VEC[i][0]);
        end

        // R1 response lasts one cycle and ready returns
        access("R1", 1'b0, 2'd2, 32'h14, 32'h0, 32'h5, 1'b0, 1'b0);
        @(negedge clk);
        chk("R1", "rsp_valid after response", {31'b0, rsp_valid}, 32'd0);
        chk("R1", "req_ready after response", {31'b0, req_ready}, 32'd1);

        // R1 held request: taken once per idle cycle
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = 32'h38;
        @(negedge clk);
        chk("R1", "held req first rsp", {31'b0, rsp_valid}, 32'd1);
        @(negedge clk);
        chk("R1", "held req gap", {31'b0, rsp_valid}, 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1", "held req second rsp", {31'b0, rsp_valid}, 32'd1);

        // R3 R4 R5 with other input values
        refclk_mhz = 8'd100; link_en = 3'b011; mem_gbytes = 4'd1;
        access("R3", 1'b0, 2'd2, 32'h30, 32'h0, 32'h0101_6401, 1'b0, 1'b0);
        access("R4", 1'b0, 2'd2, 32'h34, 32'h0, 32'h0000_0006, 1'b0, 1'b0);
        access("R5", 1'b0, 2'd2, 32'h38, 32'h0, 32'h0000_FFF1, 1'b0, 1'b0);
        link_en = 3'b111; mem_gbytes = 4'hF;
        access("R4", 1'b0, 2'd2, 32'h34, 32'h0, 32'h0000_000E, 1'b0, 1'b0);
        access("R5", 1'b0, 2'd2, 32'h38, 32'h0, 32'h0000_FFFF, 1'b0, 1'b0);

        // R7 R11 reset command through upper address bits, then no pulse after
        access("R7", 1'b1, 2'd2, 32'h5555_0010, 32'h0000_0010, 32'h0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R7", "reset pulse ended", {31'b0, sys_reset_req}, 32'd0);

        // R8 writes to read-only status words leave values intact
        access("R8", 1'b1, 2'd2, 32'h18, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0);
        access("R8", 1'b1, 2'd2, 32'h38, 32'h0000_0000, 32'h0, 1'b0, 1'b0);
        access("R8", 1'b0, 2'd2, 32'h38, 32'h0, 32'h0000_FFFF, 1'b0, 1'b0);
        access("R8", 1'b1, 2'd2, 32'h00, 32'hDEAD_BEEF, 32'h0, 1'b0, 1'b0);
        access("R8", 1'b0, 2'd2, 32'h00, 32'h0, 32'h0, 1'b0, 1'b0);

        // R9 read of link status word and unaligned write are unknown
        access("R9", 1'b0, 2'd2, 32'h18, 32'h0, 32'h0, 1'b1, 1'b0);
        access("R9", 1'b1, 2'd2, 32'h12, 32'h10, 32'h0, 1'b1, 1'b0);

        // R6 wrong-size read of a normally non-zero word
        access("R6", 1'b0, 2'd1, 32'h38, 32'h0, 32'h0, 1'b1, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule